// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block sits between an internal master that can issue requests up to 64 bits wide and a narrow external memory or peripheral bus. It turns one internal request (a byte, half-word, word or double-word single access, or a burst of double-words) into an ordered run of external cycles. The number of cycles depends on the external data width chosen by a two-bit select: 8, 16 or 32 bits.

Every request begins with one address-latch cycle. In that cycle the high physical address bits are driven on the top pins of the address bus, and a strobe marks them for an external latch. Data cycles follow, one per clock. Each carries the width-shifted low address, byte-lane enables and, for writes, the bytes that belong on those lanes. On reads the block gathers the returned lanes into the internal read word in little-endian order. One done pulse closes the request.

Top module: `bus_size_seq`

## Requirements
- R1: `widthSel` code 0 selects an 8-bit bus, 1 selects 16-bit, and 2 or 3 select 32-bit. The code and all request fields are captured when a request is accepted. Changing them while a request is in progress has no effect on it.
- R2: In the clock after acceptance, `extAle` is high for exactly one cycle and `extCyc` is low. `extAddr[19:12]` carries physical bits [27:20], [28:21] or [29:22] for the 8-, 16- or 32-bit bus, and `extAddr[11:0]` is zero. This phase occurs once per request, burst included.
- R3: During each data cycle, `extAddr` carries the physical byte address of that cycle shifted right by 0, 1 or 2 bits for the 8-, 16- or 32-bit bus, so it holds bits [19:0], [20:1] or [21:2].
- R4: A single access of 2^size bytes (`reqSize` 0 byte, 1 half-word, 2 word, 3 double-word) takes 2^size/W data cycles when it is wider than the bus width W in bytes, and one cycle otherwise.
- R5: A burst (`reqBurst`=1) moves BURST_BEATS double-words from an 8-byte-aligned address. Each beat takes 8/W data cycles, so there are 8·BURST_BEATS/W cycles in all.
- R6: Data cycles run from the lowest address upward, and `extAddr` rises by one on each successive data cycle.
- R7: Bit j of `extLaneEn` enables the data pins [8j+7:8j]. Only lanes below W are used. A narrow access enables the lanes starting at its address modulo W. Outside data cycles all enables are zero.
- R8: On writes, request byte i appears on the lane that carries physical address base+i, in the data cycle that covers that address. Disabled lanes are driven to zero, and `extWe` is high only during write data cycles.
- R9: On reads, the lane carrying address base+i is stored as byte i of `rdData` (bits [8i+7:8i]). The bytes beyond the request size read as zero, and `rdData` is valid from the done pulse until the next acceptance.
- R10: `reqDone` is a one-cycle pulse in the clock after the last data cycle. `reqReady` is high only when no request is in progress, and `reqValid` is ignored while it is low.
- R11: While `rstN` is low, the block is idle: `reqReady`=1, and `extAle`, `extCyc`, `extWe`, `reqDone` and `extLaneEn` are all zero. A reset in the middle of a request abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| widthSel | input | 2 | External bus width code (R1) |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | Single access size code |
| reqBurst | input | 1 | Burst of BURST_BEATS double-words |
| reqAddr | input | ADDR_W (30) | Physical byte address |
| reqWdata | input | 64·BURST_BEATS | Write bytes, byte i at bits [8i+7:8i] |
| reqReady | output | 1 | Idle, a request can be accepted |
| reqDone | output | 1 | Request complete pulse |
| rdData | output | 64·BURST_BEATS | Assembled read bytes |
| extAddr | output | PIN_W (20) | External address pins |
| extAle | output | 1 | Upper-address latch strobe |
| extCyc | output | 1 | Data cycle strobe |
| extWe | output | 1 | Write data cycle |
| extLaneEn | output | 4 | Byte lane enables |
| extWdata | output | 32 | External write data |
| extRdata | input | 32 | External read data, sampled at the end of each data cycle |

## Verification
Several properties are checked by assertions on every clock:
- each latch strobe is followed by a data cycle, and the two strobes are never high together;
- the low address steps by one between adjacent data cycles;
- lane enables and write enable are confined to data cycles, and no more lanes are enabled than the width allows;
- `reqDone` is a lone pulse that follows a data cycle;
- `reqReady` excludes any bus activity.

Only the bench's scenarios can show the rest:
- the exact upper-pin mapping and the per-width shift of the low address;
- the cycle counts for each size and width, burst included;
- the write-byte placement and the little-endian read assembly;
- that a width change or a fresh request during a transfer leaves that transfer untouched.

// File: rtl/bss_pkg.sv
`timescale 1ns/1ps
package bss_pkg;

  localparam int EXT_LANES = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_XFER = 2'd2
  } seqState_t;

  typedef struct packed {
    logic load;
    logic ale;
    logic cyc;
    logic last;
  } seqStrobe_t;

  function automatic logic [1:0] widthLog2(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/bss_ctrl.sv
`timescale 1ns/1ps
module bss_ctrl
  import bss_pkg::*;
#(
  parameter int SUB_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [SUB_W-1:0] lastIdx,
  output seqStrobe_t       stb,
  output logic [SUB_W-1:0] subIdx,
  output logic             reqReady,
  output logic             reqDone
);

  seqState_t state;
  logic      isLast;

  assign isLast   = (subIdx == lastIdx);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    stb.load = reqValid && (state == ST_IDLE);
    stb.ale  = (state == ST_ADDR);
    stb.cyc  = (state == ST_XFER);
    stb.last = (state == ST_XFER) && isLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      subIdx  <= '0;
      reqDone <= 1'b0;
    end else begin
      reqDone <= (state == ST_XFER) && isLast;
      case (state)
        ST_IDLE: if (reqValid) state <= ST_ADDR;
        ST_ADDR: begin
          state  <= ST_XFER;
          subIdx <= '0;
        end
        ST_XFER: begin
          if (isLast) begin
            state  <= ST_IDLE;
            subIdx <= '0;
          end else begin
            subIdx <= subIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: an accepted request is followed by the latch phase
  p_accept_ale_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> stb.ale);

  // R2: latch phase lasts one cycle and leads into data
  p_ale_one_cycle_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.ale |=> (stb.cyc && !stb.ale));

  // R10: ready never overlaps bus activity
  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!stb.ale && !stb.cyc));

  // R10: done is a single pulse following a data cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone);
  p_done_after_data_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |-> $past(stb.cyc));

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ale, stb.cyc}));

endmodule

// File: rtl/bss_dpath.sv
`timescale 1ns/1ps
module bss_dpath
  import bss_pkg::*;
#(
  parameter int ADDR_W      = 30,
  parameter int PIN_W       = 20,
  parameter int UPPER_W     = 8,
  parameter int BURST_BEATS = 4,
  localparam int TOT_BYTES  = BURST_BEATS * 8,
  localparam int SUB_W      = $clog2(TOT_BYTES),
  localparam int DATA_W     = TOT_BYTES * 8,
  localparam int BL_W       = $clog2(SUB_W + 1),
  localparam int POS_W      = SUB_W + 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobe_t             stb,
  input  logic [SUB_W-1:0]       subIdx,
  input  logic [1:0]             widthSel,
  input  logic                   reqWrite,
  input  logic [1:0]             reqSize,
  input  logic                   reqBurst,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  input  logic [8*EXT_LANES-1:0] extRdata,
  output logic [SUB_W-1:0]       lastIdx,
  output logic [PIN_W-1:0]       extAddr,
  output logic [EXT_LANES-1:0]   extLaneEn,
  output logic [8*EXT_LANES-1:0] extWdata,
  output logic                   extWe,
  output logic [DATA_W-1:0]      rdData
);

  logic [ADDR_W-1:0] baseAddr;
  logic              isWrite;
  logic [1:0]        wl;
  logic [BL_W-1:0]   bytesLog2;
  logic [DATA_W-1:0] wdBuf;
  logic [DATA_W-1:0] rdBuf;

  // request capture at acceptance (R1)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr  <= '0;
      isWrite   <= 1'b0;
      wl        <= 2'd0;
      bytesLog2 <= '0;
      wdBuf     <= '0;
    end else if (stb.load) begin
      baseAddr  <= reqAddr;
      isWrite   <= reqWrite;
      wl        <= widthLog2(widthSel);
      bytesLog2 <= reqBurst ? BL_W'(SUB_W) : BL_W'(reqSize);
      wdBuf     <= reqWdata;
    end
  end

  // sub-cycle count
  logic [BL_W-1:0]  cycLog2;
  logic [POS_W-1:0] nBytes, widthBytes, off;

  always_comb begin
    cycLog2    = (bytesLog2 > BL_W'(wl)) ? (bytesLog2 - BL_W'(wl)) : '0;
    lastIdx    = SUB_W'((32'd1 << cycLog2) - 32'd1);
    nBytes     = POS_W'(1) << bytesLog2;
    widthBytes = POS_W'(1) << wl;
    off        = (nBytes < widthBytes)
               ? POS_W'(baseAddr[1:0] & ((2'd1 << wl) - 2'd1)) : '0;
  end

  // lane to request-byte mapping
  logic [EXT_LANES-1:0] laneVal;
  logic [SUB_W-1:0]     laneIdx [EXT_LANES];
  logic [POS_W-1:0]     posRaw  [EXT_LANES];

  always_comb begin
    for (int j = 0; j < EXT_LANES; j++) begin
      posRaw[j]  = (POS_W'(subIdx) << wl) + POS_W'(j);
      laneVal[j] = stb.cyc && (POS_W'(j) < widthBytes) && (posRaw[j] >= off)
                   && ((posRaw[j] - off) < nBytes);
      laneIdx[j] = SUB_W'(posRaw[j] - off);
    end
  end

  always_comb begin
    extWdata = '0;
    for (int j = 0; j < EXT_LANES; j++) begin
      if (laneVal[j] && isWrite)
        extWdata[8*j +: 8] = wdBuf[{laneIdx[j], 3'b000} +: 8];
    end
  end

  assign extLaneEn = laneVal;
  assign extWe     = stb.cyc && isWrite;

  // read assembly, little-endian
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdBuf <= '0;
    end else if (stb.load) begin
      rdBuf <= '0;
    end else if (stb.cyc && !isWrite) begin
      for (int j = 0; j < EXT_LANES; j++) begin
        if (laneVal[j])
          rdBuf[{laneIdx[j], 3'b000} +: 8] <= extRdata[8*j +: 8];
      end
    end
  end

  assign rdData = rdBuf;

  // address pins: upper phase, then shifted low address
  logic [ADDR_W-1:0]  curAddr;
  logic [PIN_W-1:0]   lowerPins;
  logic [UPPER_W-1:0] upperPins;

  always_comb begin
    curAddr   = baseAddr + (ADDR_W'(subIdx) << wl);
    lowerPins = PIN_W'(curAddr >> wl);
    upperPins = UPPER_W'(baseAddr >> (PIN_W + int'(wl)));
    if (stb.ale)
      extAddr = {upperPins, {(PIN_W - UPPER_W){1'b0}}};
    else if (stb.cyc)
      extAddr = lowerPins;
    else
      extAddr = '0;
  end

  // R7: no lanes outside data cycles
  p_lanes_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cyc |-> (extLaneEn == '0));

  // R7: at least one and at most W lanes in a data cycle
  p_lane_width_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.cyc |-> ((extLaneEn != '0) && ($countones(extLaneEn) <= (3'd1 << wl))));

  // R6: low address climbs by one between adjacent data cycles
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cyc && $past(stb.cyc)) |-> (extAddr == $past(extAddr) + 1'b1));

  // R1: captured width holds through the data phase
  p_width_held_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cyc && $past(stb.cyc)) |-> $stable(wl));

  // R8: write enable only in data cycles
  p_we_in_cyc_r8: assert property (@(posedge clk) disable iff (!rstN)
    extWe |-> stb.cyc);

endmodule

// File: rtl/bus_size_seq.sv
`timescale 1ns/1ps
module bus_size_seq
  import bss_pkg::*;
#(
  parameter int ADDR_W      = 30,
  parameter int PIN_W       = 20,
  parameter int UPPER_W     = 8,
  parameter int BURST_BEATS = 4,
  localparam int TOT_BYTES  = BURST_BEATS * 8,
  localparam int SUB_W      = $clog2(TOT_BYTES),
  localparam int DATA_W     = TOT_BYTES * 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             widthSel,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [1:0]             reqSize,
  input  logic                   reqBurst,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  output logic                   reqReady,
  output logic                   reqDone,
  output logic [DATA_W-1:0]      rdData,
  output logic [PIN_W-1:0]       extAddr,
  output logic                   extAle,
  output logic                   extCyc,
  output logic                   extWe,
  output logic [EXT_LANES-1:0]   extLaneEn,
  output logic [8*EXT_LANES-1:0] extWdata,
  input  logic [8*EXT_LANES-1:0] extRdata
);

  seqStrobe_t       stb;
  logic [SUB_W-1:0] subIdx;
  logic [SUB_W-1:0] lastIdx;

  bss_ctrl #(.SUB_W(SUB_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .lastIdx  (lastIdx),
    .stb      (stb),
    .subIdx   (subIdx),
    .reqReady (reqReady),
    .reqDone  (reqDone)
  );

  bss_dpath #(
    .ADDR_W      (ADDR_W),
    .PIN_W       (PIN_W),
    .UPPER_W     (UPPER_W),
    .BURST_BEATS (BURST_BEATS)
  ) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .subIdx    (subIdx),
    .widthSel  (widthSel),
    .reqWrite  (reqWrite),
    .reqSize   (reqSize),
    .reqBurst  (reqBurst),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .extRdata  (extRdata),
    .lastIdx   (lastIdx),
    .extAddr   (extAddr),
    .extLaneEn (extLaneEn),
    .extWdata  (extWdata),
    .extWe     (extWe),
    .rdData    (rdData)
  );

  assign extAle = stb.ale;
  assign extCyc = stb.cyc;

endmodule

// File: tb/tb_bus_size_seq.sv
`timescale 1ns/1ps
module tb_bus_size_seq;

  localparam int BEATS  = 4;
  localparam int DATA_W = BEATS * 64;
  localparam int NBYTES = BEATS * 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        widthSel = '0;
  logic              reqValid = 1'b0;
  logic              reqWrite = 1'b0;
  logic [1:0]        reqSize = '0;
  logic              reqBurst = 1'b0;
  logic [29:0]       reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              reqReady, reqDone;
  logic [DATA_W-1:0] rdData;
  logic [19:0]       extAddr;
  logic              extAle, extCyc, extWe;
  logic [3:0]        extLaneEn;
  logic [31:0]       extWdata;
  logic [31:0]       extRdata = '0;

  always #2.5 clk = ~clk;

  bus_size_seq #(.BURST_BEATS(BEATS)) dut (
    .clk(clk), .rstN(rstN), .widthSel(widthSel), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqSize(reqSize), .reqBurst(reqBurst),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .reqDone(reqDone), .rdData(rdData), .extAddr(extAddr), .extAle(extAle),
    .extCyc(extCyc), .extWe(extWe), .extLaneEn(extLaneEn),
    .extWdata(extWdata), .extRdata(extRdata)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] memByte(input logic [31:0] a);
    return a[7:0] ^ 8'h5A ^ {a[11:8], a[15:12]};
  endfunction

  typedef struct packed {
    logic [1:0]  ws;
    logic        wr;
    logic [1:0]  sz;
    logic        bu;
    logic [29:0] addr;
    logic [7:0]  nCyc;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{2'd2, 1'b0, 2'd0, 1'b0, 30'h2345_6783, 8'd1},
    '{2'd2, 1'b1, 2'd2, 1'b0, 30'h1000_0004, 8'd1},
    '{2'd2, 1'b0, 2'd3, 1'b0, 30'h3FFF_FFF8, 8'd2},
    '{2'd1, 1'b0, 2'd1, 1'b0, 30'h0123_4562, 8'd1},
    '{2'd1, 1'b1, 2'd2, 1'b0, 30'h0ABC_DE14, 8'd2},
    '{2'd1, 1'b0, 2'd3, 1'b0, 30'h1357_9BD8, 8'd4},
    '{2'd0, 1'b1, 2'd0, 1'b0, 30'h2222_2225, 8'd1},
    '{2'd0, 1'b0, 2'd2, 1'b0, 30'h0F0F_0F0C, 8'd4},
    '{2'd0, 1'b1, 2'd3, 1'b0, 30'h1111_1110, 8'd8},
    '{2'd2, 1'b1, 2'd0, 1'b1, 30'h0200_0020, 8'd8},
    '{2'd1, 1'b0, 2'd0, 1'b1, 30'h0300_0040, 8'd16},
    '{2'd0, 1'b0, 2'd0, 1'b1, 30'h0000_0080, 8'd32},
    '{2'd3, 1'b1, 2'd1, 1'b0, 30'h0000_0006, 8'd1},
    '{2'd2, 1'b0, 2'd0, 1'b0, 30'h2000_0001, 8'd1}
  };

  task automatic runReq(input vec_t v, input bit poke);
    int wl, wdt, nb, off, idx;
    string cntTag;
    logic [DATA_W-1:0] wd, expRd;
    logic [31:0] expW;
    logic [3:0]  expLn;
    logic [19:0] expA;
    wl     = (v.ws == 2'd0) ? 0 : (v.ws == 2'd1) ? 1 : 2;   // R1
    wdt    = 1 << wl;
    nb     = v.bu ? NBYTES : (1 << v.sz);
    off    = (nb < wdt) ? (int'(v.addr[1:0]) % wdt) : 0;
    cntTag = v.bu ? "R5" : "R4";
    for (int b = 0; b < NBYTES; b++) wd[b*8 +: 8] = 8'(b * 29 + int'(v.addr[7:0]) + 3);

    @(negedge clk);
    widthSel = v.ws; reqWrite = v.wr; reqSize = v.sz; reqBurst = v.bu;
    reqAddr = v.addr; reqWdata = wd; reqValid = 1'b1;

    @(negedge clk);
    reqValid = 1'b0;
    chk(extAle === 1'b1 && extCyc === 1'b0, "R2", "latch strobe", DATA_W'({extAle, extCyc}), 2'b10);
    expA = 20'((v.addr >> (20 + wl)) & 30'hFF) << 12;
    chk(extAddr === expA, "R2", "upper pins", DATA_W'(extAddr), DATA_W'(expA));

    for (int k = 0; k < int'(v.nCyc); k++) begin
      @(negedge clk);
      chk(extCyc === 1'b1 && extAle === 1'b0, cntTag, "data cycle present", DATA_W'(extCyc), 1);
      expA = 20'((v.addr >> wl) + 30'(k));
      chk(extAddr === expA, "R3", "low address (R6 order)", DATA_W'(extAddr), DATA_W'(expA));
      expLn = '0; expW = '0;
      for (int j = 0; j < 4; j++) begin
        idx = k * wdt + j - off;
        if (j < wdt && idx >= 0 && idx < nb) begin
          expLn[j] = 1'b1;
          expW[j*8 +: 8] = wd[idx*8 +: 8];
        end
      end
      chk(extLaneEn === expLn, "R7", "lane enables", DATA_W'(extLaneEn), DATA_W'(expLn));
      chk(extWe === v.wr, "R8", "write enable", DATA_W'(extWe), DATA_W'(v.wr));
      if (v.wr)
        chk(extWdata === expW, "R8", "write lanes", DATA_W'(extWdata), DATA_W'(expW));
      else
        for (int j = 0; j < 4; j++)
          extRdata[j*8 +: 8] = memByte((32'(extAddr) << wl) + 32'(j));
      if (poke && k == 0) begin
        reqValid = 1'b1;
        reqAddr  = ~v.addr;
        reqWdata = ~wd;
        widthSel = (v.ws == 2'd2) ? 2'd0 : 2'd2;
      end else begin
        reqValid = 1'b0;
        widthSel = v.ws;
      end
    end

    @(negedge clk);
    reqValid = 1'b0;
    widthSel = v.ws;
    chk(extCyc === 1'b0, cntTag, "cycle count ends", DATA_W'(extCyc), 0);
    chk(reqDone === 1'b1 && reqReady === 1'b1, "R10", "done and ready", DATA_W'({reqDone, reqReady}), 2'b11);
    if (!v.wr) begin
      expRd = '0;
      for (int i = 0; i < nb; i++) expRd[i*8 +: 8] = memByte(32'(v.addr) + 32'(i));
      chk(rdData === expRd, "R9", "read assembly", rdData, expRd);
    end

    @(negedge clk);
    chk(reqDone === 1'b0, "R10", "done is one pulse", DATA_W'(reqDone), 0);
    if (poke)
      chk(extAle === 1'b0 && extCyc === 1'b0, "R10", "busy request ignored", DATA_W'({extAle, extCyc}), 0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs while held in reset
    chk(reqReady === 1'b1 && reqDone === 1'b0, "R11", "reset handshake", DATA_W'({reqReady, reqDone}), 2'b10);
    chk(extAle === 1'b0 && extCyc === 1'b0 && extWe === 1'b0 && extLaneEn === 4'b0,
        "R11", "reset bus idle", DATA_W'({extAle, extCyc, extWe, extLaneEn}), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int n = 0; n < NVEC; n++) runReq(VECS[n], 1'b0);

    // R1 / R10: width change and new request during transfers
    runReq(VECS[5], 1'b1);
    runReq(VECS[9], 1'b1);
    runReq(VECS[0], 1'b1);

    // R11: reset in the middle of an 8-bit double-word read
    @(negedge clk);
    widthSel = 2'd0; reqWrite = 1'b0; reqSize = 2'd3; reqBurst = 1'b0;
    reqAddr = 30'h0000_1000; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    chk(extCyc === 1'b1, "R11", "transfer under way", DATA_W'(extCyc), 1);
    rstN = 1'b0;
    #1;
    chk(extCyc === 1'b0 && extLaneEn === 4'b0 && reqReady === 1'b1, "R11", "async abandon",
        DATA_W'({extCyc, extLaneEn, reqReady}), 1);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(extAle === 1'b0 && extCyc === 1'b0 && reqDone === 1'b0, "R11", "stays idle after reset",
        DATA_W'({extAle, extCyc, reqDone}), 0);
    runReq(VECS[7], 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule